// File: doc/BRIEF.md
# Dual-Channel Prescaled Pulse Width Modulator

This block generates two independent pulse-width-modulated outputs from one input clock. Each channel first divides the clock by a programmable 6-bit prescaler. It then counts ticks of that divided clock through a programmable 10-bit period, and it holds its output high for a programmable number of ticks at the start of each period. A simple write port (valid, address, data) and a combinational read port give access to three settings registers per channel. Each channel has its own enable input that starts and stops it.

Settings written while a channel runs are held in shadow registers. They are copied into the working compare values only when a period ends, so no period mixes old and new settings. A duty flag can force the output high for the whole period. A stop-mode bit chooses what happens when the enable drops: with the bit clear the channel finishes its current period, and with the bit set the period is cut short on the next clock and the output goes low.

Top module: `pwm_dual_prescaled`

## Requirements
- R1: After reset both outputs are low and every mapped register reads 0.
- R2: Each channel has three registers. The control register sits at offset 0x0: bits [5:0] are the prescale value and bit 6 is the stop-mode bit. The duty register sits at offset 0x4: bits [9:0] are the duty count and bit 10 is the force-high flag. The period register sits at offset 0x8: bits [9:0] are the period value. Channel 0 uses base address 0x00 and channel 1 uses base 0x10. A read returns the last value written, with bits that are not implemented reading 0.
- R3: A write to an address that maps to no register (for example 0x0C, 0x02 or 0x1C) changes no register.
- R4: Let the prescale value be p, the period value be v and the duty count be d. Once the enable is sampled high on an idle channel, its output repeats a pattern of (p+1)*(v+1) clocks. The pattern is high for the first (p+1)*d clocks and low for the rest, and it starts on the clock after the enable was sampled.
- R5: A duty count of 0 gives a constantly low output. A duty count of v+1 or more gives a constantly high output.
- R6: With the force-high flag set, the output stays high for the whole period whatever the duty count holds.
- R7: Writes to the prescale, duty and period fields take effect only at the next period boundary of a running channel.
- R8: When the enable is deasserted and the stop-mode bit is 0, the current period completes and the output is low from the following clock on.
- R9: When the enable is deasserted and the stop-mode bit is 1, the output is low from the next clock on, and the period is not completed.
- R10: The two channels are independent: a channel whose enable is low keeps its output low while the other channel runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_vld | input | 1 | Write strobe for one clock |
| wr_addr | input | 5 | Write byte address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 5 | Read byte address |
| rd_data | output | 16 | Read data, combinational from rd_addr; 0 for unmapped addresses |
| ch_en | input | 2 | Per-channel run enable |
| pwm_out | output | 2 | Per-channel PWM output, active high |

## Verification
The assertions assume that the enable inputs and the write port are synchronous to the clock and steady around its rising edge. They also assume that a write is held for exactly one clock. The bench drives every input on the falling edge, and each write task raises the strobe for a single cycle. It enables a channel only after that channel has been stopped long enough to be idle, so every measured waveform starts at a known phase. Mid-period writes and enable drops are placed at known cycle indices away from period boundaries. This keeps the expected waveform exact.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int PRE_W = 6;
  localparam int CNT_W = 10;

  localparam logic [3:0] OFF_CTRL = 4'h0;
  localparam logic [3:0] OFF_DUTY = 4'h4;
  localparam logic [3:0] OFF_PER  = 4'h8;

  typedef struct packed {
    logic             stop_now;
    logic [PRE_W-1:0] pre;
  } ctrl_t;

  typedef struct packed {
    logic             force_hi;
    logic [CNT_W-1:0] cnt;
  } duty_t;
endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int          ADDR_W = 5,
  parameter int          DATA_W = 16,
  parameter int unsigned CH_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_vld,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_val,
  output ctrl_t             ctrl_o,
  output duty_t             duty_o,
  output logic [CNT_W-1:0]  per_o
);
  localparam int SEL_W = ADDR_W - 4;
  localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(CH_IDX);

  ctrl_t            ctrl_q, ctrl_d;
  duty_t            duty_q, duty_d;
  logic [CNT_W-1:0] per_q,  per_d;

  logic wr_ch, wr_ctrl, wr_duty, wr_per, wr_hit;
  logic rd_ch;
  logic unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:11];

  assign wr_ch   = wr_vld && (wr_addr[ADDR_W-1:4] == MY_SEL);
  assign wr_ctrl = wr_ch && (wr_addr[3:0] == OFF_CTRL);
  assign wr_duty = wr_ch && (wr_addr[3:0] == OFF_DUTY);
  assign wr_per  = wr_ch && (wr_addr[3:0] == OFF_PER);
  assign wr_hit  = wr_ctrl || wr_duty || wr_per;

  always_comb begin
    ctrl_d = ctrl_q;
    duty_d = duty_q;
    per_d  = per_q;
    if (wr_ctrl) ctrl_d = wr_data[PRE_W:0];
    if (wr_duty) duty_d = wr_data[CNT_W:0];
    if (wr_per)  per_d  = wr_data[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      duty_q <= '0;
      per_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      duty_q <= duty_d;
      per_q  <= per_d;
    end
  end

  assign rd_ch = (rd_addr[ADDR_W-1:4] == MY_SEL);

  always_comb begin
    rd_val = '0;
    if (rd_ch) begin
      unique case (rd_addr[3:0])
        OFF_CTRL: rd_val = DATA_W'(ctrl_q);
        OFF_DUTY: rd_val = DATA_W'(duty_q);
        OFF_PER:  rd_val = DATA_W'(per_q);
        default:  rd_val = '0;
      endcase
    end
  end

  assign ctrl_o = ctrl_q;
  assign duty_o = duty_q;
  assign per_o  = per_q;

  // R3
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit) |=> $stable({ctrl_q, duty_q, per_q}));
endmodule

// File: rtl/pwm_core.sv
module pwm_core
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  ctrl_t            ctrl_i,
  input  duty_t            duty_i,
  input  logic [CNT_W-1:0] per_i,
  output logic             pwm_o
);
  logic             run_q,  run_d;
  logic [PRE_W-1:0] pc_q,   pc_d;
  logic [CNT_W-1:0] cnt_q,  cnt_d;
  logic [PRE_W-1:0] a_pre_q, a_pre_d;
  logic [CNT_W-1:0] a_pv_q,  a_pv_d;
  duty_t            a_duty_q, a_duty_d;

  logic pre_done, per_done, cut_now;

  assign pre_done = (pc_q == a_pre_q);
  assign per_done = pre_done && (cnt_q == a_pv_q);
  assign cut_now  = !en_i && ctrl_i.stop_now;

  always_comb begin
    run_d    = run_q;
    pc_d     = pc_q;
    cnt_d    = cnt_q;
    a_pre_d  = a_pre_q;
    a_pv_d   = a_pv_q;
    a_duty_d = a_duty_q;
    if (!run_q) begin
      if (en_i) begin
        run_d    = 1'b1;
        pc_d     = '0;
        cnt_d    = '0;
        a_pre_d  = ctrl_i.pre;
        a_pv_d   = per_i;
        a_duty_d = duty_i;
      end
    end else if (cut_now) begin
      run_d = 1'b0;
      pc_d  = '0;
      cnt_d = '0;
    end else if (per_done) begin
      pc_d  = '0;
      cnt_d = '0;
      if (en_i) begin
        a_pre_d  = ctrl_i.pre;
        a_pv_d   = per_i;
        a_duty_d = duty_i;
      end else begin
        run_d = 1'b0;
      end
    end else if (pre_done) begin
      pc_d  = '0;
      cnt_d = cnt_q + 1'b1;
    end else begin
      pc_d = pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      pc_q     <= '0;
      cnt_q    <= '0;
      a_pre_q  <= '0;
      a_pv_q   <= '0;
      a_duty_q <= '0;
    end else begin
      run_q    <= run_d;
      pc_q     <= pc_d;
      cnt_q    <= cnt_d;
      a_pre_q  <= a_pre_d;
      a_pv_q   <= a_pv_d;
      a_duty_q <= a_duty_d;
    end
  end

  assign pwm_o = run_q && (a_duty_q.force_hi || (cnt_q < a_duty_q.cnt));

  // R9
  abrupt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cut_now) |=> !pwm_o);

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !per_done && !cut_now) |=> $stable({a_pre_q, a_pv_q, a_duty_q}));

  // R4
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (pc_q <= a_pre_q) && (cnt_q <= a_pv_q));

  // R8
  graceful_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !en_i && !ctrl_i.stop_now && !per_done) |=> run_q);
endmodule

// File: rtl/pwm_dual_prescaled.sv
module pwm_dual_prescaled
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_vld,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NUM_CH-1:0] ch_en,
  output logic [NUM_CH-1:0] pwm_out
);
  logic rst_n_s;
  logic [DATA_W-1:0] rd_vals [NUM_CH];

  pwm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    ctrl_t            ctrl;
    duty_t            duty;
    logic [CNT_W-1:0] per;

    pwm_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CH_IDX (g)
    ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .wr_vld  (wr_vld),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_val  (rd_vals[g]),
      .ctrl_o  (ctrl),
      .duty_o  (duty),
      .per_o   (per)
    );

    pwm_core u_core (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .en_i   (ch_en[g]),
      .ctrl_i (ctrl),
      .duty_i (duty),
      .per_i  (per),
      .pwm_o  (pwm_out[g])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CH; i++) rd_data = rd_data | rd_vals[i];
  end
endmodule

// File: tb/pwm_dual_prescaled_tb.sv
`timescale 1ns/1ps
module pwm_dual_prescaled_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_vld = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [1:0]  ch_en = '0;
  logic [1:0]  pwm_out;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pwm_dual_prescaled u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_vld  (wr_vld),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .ch_en   (ch_en),
    .pwm_out (pwm_out)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit exp_out(int i, int pre, int pv, int dc, bit full);
    int per = (pre + 1) * (pv + 1);
    int d   = (dc > pv + 1) ? pv + 1 : dc;
    return full || ((i % per) < (pre + 1) * d);
  endfunction

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_vld = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_vld = 1'b0;
  endtask

  task automatic rd_chk(string req, input logic [4:0] a, int exp);
    @(negedge clk);
    rd_addr = a;
    #1;
    check(req, int'(rd_data), exp);
  endtask

  task automatic cfg(int ch, int pre, bit sd, bit full, int dc, int pv);
    logic [4:0] b = (ch == 1) ? 5'h10 : 5'h00;
    wr(b | 5'h0, 16'((int'(sd) << 6) | pre));
    wr(b | 5'h4, 16'((int'(full) << 10) | dc));
    wr(b | 5'h8, 16'(pv));
  endtask

  task automatic halt(int ch);
    @(negedge clk);
    ch_en[ch] = 1'b0;
    repeat (300) @(negedge clk);
  endtask

  // Enable channel ch and compare n cycles against the computed pattern;
  // the other (disabled) channel must stay low throughout.
  task automatic run_wave(string req, int ch, int pre, int pv, int dc, bit full, int n);
    int bad = 0, bad_i = -1, a_v = 0, e_v = 0, other_hi = 0;
    @(negedge clk);
    ch_en[ch] = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[ch] !== exp_out(i, pre, pv, dc, full)) begin
        if (bad == 0) begin
          bad_i = i; a_v = int'(pwm_out[ch]); e_v = int'(exp_out(i, pre, pv, dc, full));
        end
        bad++;
      end
      if (pwm_out[1-ch] !== 1'b0) other_hi++;
    end
    if (bad != 0) $display("  first mismatch at cycle %0d", bad_i);
    check(req, a_v, e_v);
    check({req, " R10 other channel low"}, other_hi, 0);
  endtask

  task automatic t_reset();
    check("R1 outputs low", int'(pwm_out), 0);
    for (int k = 0; k < 2; k++) begin
      rd_chk("R1 ctrl", 5'(k * 16 + 0), 0);
      rd_chk("R1 duty", 5'(k * 16 + 4), 0);
      rd_chk("R1 per",  5'(k * 16 + 8), 0);
    end
  endtask

  task automatic t_regmap();
    wr(5'h00, 16'hFFAB); wr(5'h04, 16'hF5A5); wr(5'h08, 16'hFC33);
    wr(5'h10, 16'h0015); wr(5'h14, 16'h0123); wr(5'h18, 16'h0200);
    rd_chk("R2 ch0 ctrl", 5'h00, 'h2B);
    rd_chk("R2 ch0 duty", 5'h04, 'h5A5);
    rd_chk("R2 ch0 per",  5'h08, 'h033);
    rd_chk("R2 ch1 ctrl", 5'h10, 'h15);
    rd_chk("R2 ch1 duty", 5'h14, 'h123);
    rd_chk("R2 ch1 per",  5'h18, 'h200);
  endtask

  task automatic t_unmapped();
    wr(5'h0C, 16'h7FF); wr(5'h02, 16'h7FF); wr(5'h1C, 16'h7FF); wr(5'h11, 16'h7FF);
    rd_chk("R3 ch0 ctrl", 5'h00, 'h2B);
    rd_chk("R3 ch0 duty", 5'h04, 'h5A5);
    rd_chk("R3 ch0 per",  5'h08, 'h033);
    rd_chk("R3 ch1 ctrl", 5'h10, 'h15);
    rd_chk("R3 ch1 duty", 5'h14, 'h123);
    rd_chk("R3 ch1 per",  5'h18, 'h200);
    rd_chk("R3 unmapped reads 0", 5'h0C, 0);
  endtask

  task automatic t_basic();
    cfg(0, 2, 0, 0, 4, 9);  run_wave("R4 pre2 pv9 dc4", 0, 2, 9, 4, 0, 90);  halt(0);
    cfg(0, 0, 0, 0, 3, 4);  run_wave("R4 pre0 pv4 dc3", 0, 0, 4, 3, 0, 25);  halt(0);
    cfg(1, 3, 0, 0, 5, 7);  run_wave("R4 R10 ch1 pre3 pv7 dc5", 1, 3, 7, 5, 0, 96); halt(1);
  endtask

  task automatic t_edges();
    cfg(0, 1, 0, 0, 0, 6);   run_wave("R5 dc0 low", 0, 1, 6, 0, 0, 42);       halt(0);
    cfg(0, 1, 0, 0, 15, 9);  run_wave("R5 dc above pv+1 high", 0, 1, 9, 15, 0, 60); halt(0);
    cfg(0, 0, 0, 0, 1, 0);   run_wave("R5 one-clock period", 0, 0, 0, 1, 0, 10); halt(0);
  endtask

  task automatic t_full();
    cfg(0, 2, 0, 1, 2, 5);   run_wave("R6 force high", 0, 2, 5, 2, 1, 54);     halt(0);
  endtask

  task automatic t_shadow();
    int bad = 0;
    cfg(0, 1, 0, 0, 2, 5);
    @(negedge clk);
    ch_en[0] = 1'b1;
    for (int i = 0; i < 36; i++) begin
      @(negedge clk);
      if (pwm_out[0] !== exp_out(i, 1, 5, (i < 12) ? 2 : 5, 0)) bad++;
      if (i == 3) begin wr_vld = 1'b1; wr_addr = 5'h04; wr_data = 16'd5; end
      if (i == 4) wr_vld = 1'b0;
    end
    check("R7 duty change waits for boundary", bad, 0);
    halt(0);
  endtask

  task automatic t_stop(bit sd);
    int bad = 0;
    int last = sd ? 15 : 23;
    cfg(0, 1, sd, 0, 3, 5);
    @(negedge clk);
    ch_en[0] = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pwm_out[0] !== ((i <= last) ? exp_out(i, 1, 5, 3, 0) : 1'b0)) bad++;
      if (i == 15) ch_en[0] = 1'b0;
    end
    if (sd) check("R9 abrupt stop", bad, 0);
    else    check("R8 graceful stop", bad, 0);
    halt(0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regmap();
    t_unmapped();
    t_basic();
    t_edges();
    t_full();
    t_shadow();
    t_stop(1'b0);
    t_stop(1'b1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule